// File: doc/BRIEF.md
# Banked Query Response Formatter

This block forms the value returned by a read while a bank of parallel flash devices is in identifier mode or in table query mode. The caller presents a byte offset, the width of the read, and three static widths in bytes: the bank width (all devices side by side), the width at which each device is used, and the widest mode the device supports. Each width is 1, 2 or 4. The block scales the offset down to the index that one device would see and fetches one table byte or one identifier code. It then builds the whole bus word from that answer.

Two kinds of duplication shape the result. A wide device run in byte mode repeats its table byte across its full native width instead of padding with zeros. Every device in the bank then answers alike, so the per-device response is copied into each device lane of the bank word. A read wider than the bank is assembled from several bank-wide queries at successive offsets. The result is registered, with a one-cycle valid pulse, one clock after a read strobe.

Top module: `bank_query_fmt`

## Requirements
- R1: The table or identifier index equals the offset shifted right by log2(bankBytes) + log2(maxDevBytes) − log2(devBytes).
- R2: In query mode (queryMode=1) an index of 82 or more reads as zero. The full index is compared, not only its low bits.
- R3: In query mode with devBytes=1 and maxDevBytes greater than 1, the table byte fills every byte of the device's native width. Each bank byte then carries that table byte.
- R4: In query mode with devBytes different from maxDevBytes and devBytes not equal to 1, the response is zero.
- R5: When devBytes is less than bankBytes, the low devBytes bytes of the per-device response are copied into each successive devBytes-wide slice of the bank word.
- R6: In identifier mode (queryMode=0) only index bits [7:0] are decoded. Index 0 gives the manufacturer code (default 16'h00C2), index 1 gives the device code (default 16'h22A7), and every other index gives zero.
- R7: When accBytes exceeds bankBytes, the result is made of accBytes/bankBytes bank-wide queries. Query k uses offset + k·bankBytes and fills byte slice k of rdData, least significant first.
- R8: Table entries 0x10, 0x11 and 0x12 hold 0x51, 0x52 and 0x59 ("QRY"). Entry 0x2C (erase region count) holds 0x01, and entry 0x51 holds 0xA5.
- R9: rdData and rdValid update on the first rising edge after rdStrobe is sampled high. rdValid is high for exactly that one cycle. rdData holds its value while no strobe is seen.
- R10: While rstN is low, rdValid and rdData are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdStrobe | input | 1 | Read request, one cycle |
| queryMode | input | 1 | 1 selects table query, 0 selects identifier read |
| offset | input | 16 | Byte offset of the read |
| accBytes | input | 3 | Read width in bytes (1, 2, 4) |
| bankBytes | input | 3 | Bank width in bytes (1, 2, 4), static |
| devBytes | input | 3 | Width each device is used at, in bytes, static |
| maxDevBytes | input | 3 | Native maximum device width in bytes, static |
| rdData | output | 32 | Registered response word |
| rdValid | output | 1 | Pulses high with each new rdData |

## Verification
The formatter is tried with a byte-wide bank at matched widths, 2- and 4-byte banks built from narrower devices, wide devices run in byte mode, and reads wider than the bank. Each pattern separates a different term of the index shift and a different form of duplication. Zero padding, lane copying and in-device widening each give a distinct word from the same table byte. Offsets just below and at the table end, together with offsets whose low eight index bits alias entries 0 and 1, tell a full-index compare apart from a truncated one. Reads without a strobe show whether the output register holds its value.

// File: rtl/qrf_pkg.sv
package qrf_pkg;

  typedef struct packed {
    logic load;
    logic isQuery;
  } fmtCtrl_t;

  function automatic int widthLog2(input logic [2:0] w);
    int r;
    r = 0;
    for (int i = 0; i < 3; i++) begin
      if (w[i]) r = i;
    end
    return r;
  endfunction

  function automatic logic [7:0] tableByte(input logic [7:0] i,
                                           input logic [7:0] sizeLog2);
    logic [7:0] b;
    case (i)
      8'h10: b = 8'h51;
      8'h11: b = 8'h52;
      8'h12: b = 8'h59;
      8'h13: b = 8'h01;
      8'h15: b = 8'h31;
      8'h1B: b = 8'h45;
      8'h1C: b = 8'h55;
      8'h27: b = sizeLog2;
      8'h28: b = 8'h02;
      8'h2C: b = 8'h01;
      8'h31: b = 8'h50;
      8'h32: b = 8'h52;
      8'h33: b = 8'h49;
      8'h51: b = 8'hA5;
      default: b = 8'h00;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/qrf_ctrl.sv
module qrf_ctrl
  import qrf_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     rdStrobe,
  input  logic     queryMode,
  output fmtCtrl_t ctl,
  output logic     rdValid
);

  always_comb begin
    ctl.load    = rdStrobe;
    ctl.isQuery = queryMode;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdValid <= 1'b0;
    else       rdValid <= rdStrobe;
  end

  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rstN)
    rdStrobe |=> rdValid);
  assert_valid_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    !rdStrobe |=> !rdValid);

endmodule

// File: rtl/qrf_lane.sv
module qrf_lane
  import qrf_pkg::*;
#(
  parameter int OFF_W       = 16,
  parameter int BUS_BYTES   = 4,
  parameter int TABLE_DEPTH = 82,
  parameter logic [15:0] MFR_CODE  = 16'h00C2,
  parameter logic [15:0] DEV_CODE  = 16'h22A7,
  parameter logic [7:0]  SIZE_LOG2 = 8'h17
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   isQuery,
  input  logic [OFF_W-1:0]       offset,
  input  logic [2:0]             bankBytes,
  input  logic [2:0]             devBytes,
  input  logic [2:0]             maxDevBytes,
  output logic [8*BUS_BYTES-1:0] laneWord
);

  localparam int DATA_W = 8 * BUS_BYTES;
  localparam int SH_W   = $clog2(2 * $clog2(BUS_BYTES) + 1) + 1;

  logic [SH_W-1:0]   shiftAmt;
  logic [OFF_W-1:0]  idx;
  logic              idxInRange;
  logic [7:0]        tblByte;
  logic [DATA_W-1:0] devResp;

  always_comb begin
    shiftAmt = SH_W'(widthLog2(bankBytes) + widthLog2(maxDevBytes)
                     - widthLog2(devBytes));
    idx        = offset >> shiftAmt;
    idxInRange = idx < OFF_W'(TABLE_DEPTH);
    tblByte    = tableByte(idx[7:0], SIZE_LOG2);
  end

  always_comb begin
    devResp = '0;
    if (isQuery) begin
      if (idxInRange) begin
        if (devBytes == maxDevBytes) begin
          devResp[7:0] = tblByte;
        end else if (devBytes == 3'd1) begin
          for (int j = 0; j < BUS_BYTES; j++) begin
            if (j < int'(maxDevBytes)) devResp[8*j +: 8] = tblByte;
          end
        end
      end
    end else begin
      case (idx[7:0])
        8'd0:    devResp[15:0] = MFR_CODE;
        8'd1:    devResp[15:0] = DEV_CODE;
        default: devResp = '0;
      endcase
    end
  end

  always_comb begin
    laneWord = '0;
    for (int j = 0; j < BUS_BYTES; j++) begin
      if (j < int'(bankBytes)) begin
        laneWord[8*j +: 8] = devResp[8*(j & (int'(devBytes) - 1)) +: 8];
      end
    end
  end

  assert_range_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    (isQuery && !idxInRange) |-> (laneWord == '0));
  assert_bad_mix_R4: assert property (@(posedge clk) disable iff (!rstN)
    (isQuery && devBytes != maxDevBytes && devBytes != 3'd1) |-> (laneWord == '0));
  assert_byte_mode_fill_R3: assert property (@(posedge clk) disable iff (!rstN)
    (isQuery && bankBytes == 3'd4 && devBytes == 3'd1 && maxDevBytes == 3'd4)
      |-> (laneWord[31:24] == laneWord[7:0] && laneWord[15:8] == laneWord[7:0]));

endmodule

// File: rtl/qrf_datapath.sv
module qrf_datapath
  import qrf_pkg::*;
#(
  parameter int OFF_W       = 16,
  parameter int BUS_BYTES   = 4,
  parameter int TABLE_DEPTH = 82,
  parameter logic [15:0] MFR_CODE  = 16'h00C2,
  parameter logic [15:0] DEV_CODE  = 16'h22A7,
  parameter logic [7:0]  SIZE_LOG2 = 8'h17
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  fmtCtrl_t               ctl,
  input  logic [OFF_W-1:0]       offset,
  input  logic [2:0]             accBytes,
  input  logic [2:0]             bankBytes,
  input  logic [2:0]             devBytes,
  input  logic [2:0]             maxDevBytes,
  output logic [8*BUS_BYTES-1:0] rdData
);

  localparam int DATA_W = 8 * BUS_BYTES;

  logic [DATA_W-1:0] laneWord [BUS_BYTES];
  logic [DATA_W-1:0] assembled;
  int                numSlices;

  for (genvar k = 0; k < BUS_BYTES; k++) begin : gSlice
    logic [OFF_W-1:0] sliceOff;
    assign sliceOff = offset + OFF_W'(k) * OFF_W'(bankBytes);

    qrf_lane #(
      .OFF_W(OFF_W), .BUS_BYTES(BUS_BYTES), .TABLE_DEPTH(TABLE_DEPTH),
      .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE), .SIZE_LOG2(SIZE_LOG2)
    ) uLane (
      .clk(clk), .rstN(rstN), .isQuery(ctl.isQuery), .offset(sliceOff),
      .bankBytes(bankBytes), .devBytes(devBytes), .maxDevBytes(maxDevBytes),
      .laneWord(laneWord[k])
    );
  end

  always_comb begin
    numSlices = (accBytes > bankBytes)
              ? (int'(accBytes) >> widthLog2(bankBytes)) : 1;
    assembled = '0;
    for (int k = 0; k < BUS_BYTES; k++) begin
      if (k < numSlices) begin
        assembled = assembled | (laneWord[k] << (8 * k * int'(bankBytes)));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)         rdData <= '0;
    else if (ctl.load) rdData <= assembled;
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load |=> $stable(rdData));
  assert_cfg_pow2_R1: assert property (@(posedge clk) disable iff (!rstN)
    $countones(bankBytes) == 1 && $countones(devBytes) == 1
      && $countones(maxDevBytes) == 1 && $countones(accBytes) == 1
      && devBytes <= maxDevBytes && devBytes <= bankBytes);

endmodule

// File: rtl/bank_query_fmt.sv
module bank_query_fmt
  import qrf_pkg::*;
#(
  parameter int OFF_W       = 16,
  parameter int BUS_BYTES   = 4,
  parameter int TABLE_DEPTH = 82,
  parameter logic [15:0] MFR_CODE  = 16'h00C2,
  parameter logic [15:0] DEV_CODE  = 16'h22A7,
  parameter logic [7:0]  SIZE_LOG2 = 8'h17
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   rdStrobe,
  input  logic                   queryMode,
  input  logic [OFF_W-1:0]       offset,
  input  logic [2:0]             accBytes,
  input  logic [2:0]             bankBytes,
  input  logic [2:0]             devBytes,
  input  logic [2:0]             maxDevBytes,
  output logic [8*BUS_BYTES-1:0] rdData,
  output logic                   rdValid
);

  fmtCtrl_t ctl;

  qrf_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .rdStrobe(rdStrobe), .queryMode(queryMode),
    .ctl(ctl), .rdValid(rdValid)
  );

  qrf_datapath #(
    .OFF_W(OFF_W), .BUS_BYTES(BUS_BYTES), .TABLE_DEPTH(TABLE_DEPTH),
    .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE), .SIZE_LOG2(SIZE_LOG2)
  ) uData (
    .clk(clk), .rstN(rstN), .ctl(ctl), .offset(offset), .accBytes(accBytes),
    .bankBytes(bankBytes), .devBytes(devBytes), .maxDevBytes(maxDevBytes),
    .rdData(rdData)
  );

endmodule

// File: tb/sim_bank_query_fmt.sv
module sim_bank_query_fmt;

  typedef struct packed {
    logic        mode;
    logic [15:0] off;
    logic [2:0]  aw;
    logic [2:0]  bw;
    logic [2:0]  dw;
    logic [2:0]  md;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NVEC = 22;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 16'h0010, 3'd1, 3'd1, 3'd1, 3'd1, 32'h00000051, 8'd8},  // R8 'Q'
    '{1'b1, 16'h0011, 3'd1, 3'd1, 3'd1, 3'd1, 32'h00000052, 8'd8},  // R8 'R'
    '{1'b1, 16'h0012, 3'd1, 3'd1, 3'd1, 3'd1, 32'h00000059, 8'd8},  // R8 'Y'
    '{1'b1, 16'h002C, 3'd1, 3'd1, 3'd1, 3'd1, 32'h00000001, 8'd8},  // R8 region count
    '{1'b1, 16'h0020, 3'd2, 3'd2, 3'd2, 3'd2, 32'h00000051, 8'd1},  // R1 bank shift
    '{1'b1, 16'h0044, 3'd4, 3'd4, 3'd2, 3'd2, 32'h00520052, 8'd5},  // R5 two lanes
    '{1'b1, 16'h0048, 3'd2, 3'd2, 3'd1, 3'd2, 32'h00005959, 8'd3},  // R3 x16 in x8
    '{1'b1, 16'h0010, 3'd4, 3'd1, 3'd1, 3'd1, 32'h01595251, 8'd7},  // R7 four slices
    '{1'b1, 16'h0020, 3'd4, 3'd2, 3'd2, 3'd2, 32'h00520051, 8'd7},  // R7 two slices
    '{1'b1, 16'h0051, 3'd1, 3'd1, 3'd1, 3'd1, 32'h000000A5, 8'd2},  // R2 last entry
    '{1'b1, 16'h0052, 3'd1, 3'd1, 3'd1, 3'd1, 32'h00000000, 8'd2},  // R2 first past end
    '{1'b1, 16'h0110, 3'd1, 3'd1, 3'd1, 3'd1, 32'h00000000, 8'd2},  // R2 no truncation
    '{1'b1, 16'h0080, 3'd4, 3'd4, 3'd2, 3'd4, 32'h00000000, 8'd4},  // R4 x32 in x16
    '{1'b1, 16'h0100, 3'd4, 3'd4, 3'd1, 3'd4, 32'h51515151, 8'd3},  // R3 x32 in x8
    '{1'b0, 16'h0000, 3'd1, 3'd1, 3'd1, 3'd1, 32'h000000C2, 8'd6},  // R6 maker
    '{1'b0, 16'h0000, 3'd2, 3'd1, 3'd1, 3'd1, 32'h0000A7C2, 8'd7},  // R7 ident pair
    '{1'b0, 16'h0002, 3'd2, 3'd2, 3'd2, 3'd2, 32'h000022A7, 8'd6},  // R6 device code
    '{1'b0, 16'h0000, 3'd4, 3'd4, 3'd2, 3'd2, 32'h00C200C2, 8'd5},  // R5 ident lanes
    '{1'b0, 16'h0004, 3'd4, 3'd4, 3'd1, 3'd1, 32'hA7A7A7A7, 8'd5},  // R5 four lanes
    '{1'b0, 16'h0002, 3'd1, 3'd1, 3'd1, 3'd1, 32'h00000000, 8'd6},  // R6 other index
    '{1'b0, 16'h0101, 3'd1, 3'd1, 3'd1, 3'd1, 32'h000000A7, 8'd6},  // R6 low 8 bits
    '{1'b0, 16'h0004, 3'd4, 3'd4, 3'd4, 3'd4, 32'h000022A7, 8'd1}   // R1 x32 shift
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rdStrobe = 1'b0;
  logic        queryMode = 1'b1;
  logic [15:0] offset = '0;
  logic [2:0]  accBytes = 3'd1;
  logic [2:0]  bankBytes = 3'd1;
  logic [2:0]  devBytes = 3'd1;
  logic [2:0]  maxDevBytes = 3'd1;
  logic [31:0] rdData;
  logic        rdValid;

  int checks = 0;
  int errors = 0;
  logic [31:0] held;

  always #4 clk = ~clk;

  bank_query_fmt u0 (
    .clk(clk), .rstN(rstN), .rdStrobe(rdStrobe), .queryMode(queryMode),
    .offset(offset), .accBytes(accBytes), .bankBytes(bankBytes),
    .devBytes(devBytes), .maxDevBytes(maxDevBytes),
    .rdData(rdData), .rdValid(rdValid)
  );

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doRead(input vec_t v);
    @(negedge clk);
    queryMode   = v.mode;
    offset      = v.off;
    accBytes    = v.aw;
    bankBytes   = v.bw;
    devBytes    = v.dw;
    maxDevBytes = v.md;
    rdStrobe    = 1'b1;
    @(negedge clk);
    rdStrobe    = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R10: reset state, with a strobe attempted during reset
    repeat (2) @(negedge clk);
    rdStrobe = 1'b1;
    @(negedge clk);
    rdStrobe = 1'b0;
    check(10, {31'd0, rdValid}, 32'd0);
    check(10, rdData, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // Vector table: R1..R8
    for (int i = 0; i < NVEC; i++) begin
      doRead(VECS[i]);
      check(VECS[i].req, rdData, VECS[i].exp);
      check(9, {31'd0, rdValid}, 32'd1);   // R9 valid with data
    end

    // R9: valid lasts one cycle and data holds without a strobe
    held = rdData;
    @(negedge clk);
    check(9, {31'd0, rdValid}, 32'd0);
    queryMode = 1'b1;
    offset    = 16'h0010;
    bankBytes = 3'd1; devBytes = 3'd1; maxDevBytes = 3'd1; accBytes = 3'd4;
    repeat (3) @(negedge clk);
    check(9, rdData, held);
    check(9, {31'd0, rdValid}, 32'd0);

    // R9: back-to-back strobes each load new data
    @(negedge clk);
    offset   = 16'h0011; accBytes = 3'd1;
    rdStrobe = 1'b1;
    @(negedge clk);
    offset   = 16'h0012;
    check(9, rdData, 32'h00000052);
    check(9, {31'd0, rdValid}, 32'd1);
    @(negedge clk);
    rdStrobe = 1'b0;
    check(9, rdData, 32'h00000059);

    // R10: reset clears the registered result
    rstN = 1'b0;
    @(negedge clk);
    check(10, rdData, 32'd0);
    check(10, {31'd0, rdValid}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule